// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This block holds the status flags of a serial port that runs either as a clock-synchronous link or as an asynchronous UART. The shift-register datapath around it reports single-cycle event strobes: a frame has fully entered the receive shift register, a frame has moved into the receive buffer, the CPU has read the receive buffer, and the transmit shifter has started or finished. From these strobes, the received parity sum, the stop-bit sample and the mode and enable control levels, the block keeps five flags. It returns them to the CPU as one status byte.

The three error flags (overrun, parity, framing) cannot be cleared one at a time. A status-register write strobe clears all three, and so does a falling edge on the port enable or the receive enable. When a set event and a clear event hit the same flag in the same cycle, the set event wins, so no error is lost. Every flag is a register, and the status byte is built from those registers by wiring alone. An event sampled at one clock edge is therefore visible on the status byte right after that edge.

Top module: `serial_status_unit`

## Requirements
- R1: Status bit 1 (receive buffer full) becomes 1 in the cycle after `rx_buf_load_i` is high.
- R2: Status bit 1 becomes 0 in the cycle after `rx_buf_read_i` is high, unless `rx_buf_load_i` is high in the same cycle, in which case it is 1.
- R3: Status bit 2 (transmit shift complete) becomes 0 after `tx_shift_start_i` and 1 after `tx_shift_end_i`. When both are high in the same cycle, the bit is 1.
- R4: Status bit 3 (overrun) becomes 1 after `rx_frame_done_i` is high while status bit 1 is 1. This applies in both modes.
- R5: In UART mode (`mode_uart_i`=1) with `parity_en_i`=1, status bit 4 becomes 1 after `rx_frame_done_i` when `rx_par_sum_i` (XOR of the received data bits and the received parity bit) differs from `parity_odd_i`. Here 0 selects even parity and 1 selects odd parity.
- R6: Status bit 4 never sets while `mode_uart_i`=0 or `parity_en_i`=0.
- R7: Status bit 5 (framing) becomes 1 after `rx_frame_done_i` in UART mode when `rx_stop_i`=0, where 0 means the stop bit was not seen. It never sets in synchronous mode.
- R8: A high `stat_wr_i` clears status bits 3, 4 and 5 in the next cycle and leaves bits 1 and 2 unchanged.
- R9: A 1-to-0 transition on `port_en_i` or on `rx_en_i` clears status bits 3, 4 and 5 in the next cycle.
- R10: A set event on an error flag beats a clear event (R8, R9) that arrives in the same cycle.
- R11: Status bits 0, 6 and 7 always read 0. After reset the status byte is 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_uart_i | input | 1 | 1 = UART mode, 0 = clock-synchronous mode |
| parity_en_i | input | 1 | Parity checking enabled |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| port_en_i | input | 1 | Port enable control level |
| rx_en_i | input | 1 | Receive enable control level |
| rx_frame_done_i | input | 1 | Strobe: full frame now in receive shift register |
| rx_buf_load_i | input | 1 | Strobe: frame moved into receive buffer |
| rx_buf_read_i | input | 1 | Strobe: CPU read of receive buffer |
| tx_shift_start_i | input | 1 | Strobe: first transmit data bit starts shifting |
| tx_shift_end_i | input | 1 | Strobe: last transmit data bit shifted out |
| rx_par_sum_i | input | 1 | XOR of received data bits and parity bit |
| rx_stop_i | input | 1 | Stop-bit sample, 1 = stop bit seen |
| stat_wr_i | input | 1 | Strobe: CPU write to status register (data ignored) |
| status_o | output | 8 | Status byte |

## Verification
Each flag is a single register that feeds the status byte directly, so a wrong internal state shows on `status_o` one cycle after the event that caused it, and it stays visible until a later clear event. A lost set-over-clear priority shows up as an error bit reading 0 right after a combined write-and-frame cycle. A wrong enable-edge detector shows up as error bits that survive a dropped enable, or that are wiped while the enables stay steady. The vectors are ordered so that each flag is set, observed, cleared and observed again before the next case starts.

// File: rtl/sp_status_pkg.sv
// Shared constants for the serial port status flag unit.
// Assumes an 8-bit status byte with flags at fixed bit positions.
package sp_status_pkg;

    localparam int STAT_W    = 8;
    localparam int NUM_FLAGS = 5;

    // Index of each flag inside the internal flag vector.
    localparam int F_RXBF = 0;
    localparam int F_TXC  = 1;
    localparam int F_OVR  = 2;
    localparam int F_PER  = 3;
    localparam int F_FER  = 4;

    // Status byte bit position of each flag, listed by flag index.
    localparam int FLAG_POS [NUM_FLAGS] = '{1, 2, 3, 4, 5};

    // Reset value of each flag: only transmit-complete starts at 1.
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 5'b00010;

    // Flags cleared together by write or enable drop.
    localparam logic [NUM_FLAGS-1:0] ERR_MASK = 5'b11100;

    typedef enum logic {
        MODE_SYNC = 1'b0,
        MODE_UART = 1'b1
    } port_mode_e;

endpackage

// File: rtl/sp_flag_cell.sv
// One status flag register with set priority over clear.
// Assumes set_i and clr_i are single-cycle strobes.
module sp_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Flag storage: reset, then set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= RST_VAL;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end

endmodule

// File: rtl/sp_clear_ctl.sv
// Builds the shared clear strobe for the error flags from the status
// write strobe and falling edges of the port and receive enables.
// Assumes enables are synchronous levels; edge state resets to 0.
module sp_clear_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en_i,
    input  logic rx_en_i,
    input  logic stat_wr_i,
    output logic err_clr_o
);

    logic port_en_q;
    logic rx_en_q;
    logic port_fall;
    logic rx_fall;

    // Remember last enable levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_en_q <= 1'b0;
            rx_en_q   <= 1'b0;
        end else begin
            port_en_q <= port_en_i;
            rx_en_q   <= rx_en_i;
        end
    end

    // Combine falling edges and status write into one clear strobe.
    always_comb begin
        port_fall = port_en_q & ~port_en_i;
        rx_fall   = rx_en_q & ~rx_en_i;
        err_clr_o = stat_wr_i | port_fall | rx_fall;
    end

endmodule

// File: rtl/sp_event_decode.sv
// Turns datapath strobes, mode bits and receive samples into per-flag
// set and clear requests. Assumes rxbf_q is the current buffer-full flag.
module sp_event_decode
    import sp_status_pkg::*;
(
    input  logic                 mode_uart_i,
    input  logic                 parity_en_i,
    input  logic                 parity_odd_i,
    input  logic                 rx_frame_done_i,
    input  logic                 rx_buf_load_i,
    input  logic                 rx_buf_read_i,
    input  logic                 tx_shift_start_i,
    input  logic                 tx_shift_end_i,
    input  logic                 rx_par_sum_i,
    input  logic                 rx_stop_i,
    input  logic                 rxbf_q_i,
    input  logic                 err_clr_i,
    output logic [NUM_FLAGS-1:0] set_o,
    output logic [NUM_FLAGS-1:0] clr_o
);

    port_mode_e mode;
    logic       par_bad;

    // Decode each flag's set and clear condition.
    always_comb begin
        mode    = port_mode_e'(mode_uart_i);
        par_bad = rx_par_sum_i ^ parity_odd_i;

        set_o = '0;
        clr_o = '0;

        set_o[F_RXBF] = rx_buf_load_i;
        clr_o[F_RXBF] = rx_buf_read_i;

        set_o[F_TXC]  = tx_shift_end_i;
        clr_o[F_TXC]  = tx_shift_start_i;

        set_o[F_OVR]  = rx_frame_done_i & rxbf_q_i;
        set_o[F_PER]  = rx_frame_done_i & (mode == MODE_UART) & parity_en_i & par_bad;
        set_o[F_FER]  = rx_frame_done_i & (mode == MODE_UART) & ~rx_stop_i;

        clr_o = clr_o | (ERR_MASK & {NUM_FLAGS{err_clr_i}});
    end

endmodule

// File: rtl/serial_status_unit.sv
// Status flag unit of a serial port: five flags kept in registers and
// presented as a status byte; unused bits read 0.
// Assumes all event inputs are single-cycle strobes synchronous to clk.
module serial_status_unit
    import sp_status_pkg::*;
#(
    parameter int OUT_W = STAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_uart_i,
    input  logic             parity_en_i,
    input  logic             parity_odd_i,
    input  logic             port_en_i,
    input  logic             rx_en_i,
    input  logic             rx_frame_done_i,
    input  logic             rx_buf_load_i,
    input  logic             rx_buf_read_i,
    input  logic             tx_shift_start_i,
    input  logic             tx_shift_end_i,
    input  logic             rx_par_sum_i,
    input  logic             rx_stop_i,
    input  logic             stat_wr_i,
    output logic [OUT_W-1:0] status_o
);

    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic                 err_clr;

    sp_clear_ctl u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en_i (port_en_i),
        .rx_en_i   (rx_en_i),
        .stat_wr_i (stat_wr_i),
        .err_clr_o (err_clr)
    );

    sp_event_decode u_dec (
        .mode_uart_i      (mode_uart_i),
        .parity_en_i      (parity_en_i),
        .parity_odd_i     (parity_odd_i),
        .rx_frame_done_i  (rx_frame_done_i),
        .rx_buf_load_i    (rx_buf_load_i),
        .rx_buf_read_i    (rx_buf_read_i),
        .tx_shift_start_i (tx_shift_start_i),
        .tx_shift_end_i   (tx_shift_end_i),
        .rx_par_sum_i     (rx_par_sum_i),
        .rx_stop_i        (rx_stop_i),
        .rxbf_q_i         (flag_q[F_RXBF]),
        .err_clr_i        (err_clr),
        .set_o            (flag_set),
        .clr_o            (flag_clr)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sp_flag_cell #(.RST_VAL(FLAG_RST[g])) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (flag_set[g]),
            .clr_i (flag_clr[g]),
            .q_o   (flag_q[g])
        );
    end

    // Place each flag at its status bit; other bits read 0.
    always_comb begin
        status_o = '0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            status_o[FLAG_POS[i]] = flag_q[i];
        end
    end

endmodule

// File: rtl/sp_status_chk.sv
// Property checker for serial_status_unit, attached by bind.
// Assumes an 8-bit status byte with flags at bits 1..5.
module sp_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_uart_i,
    input logic       parity_en_i,
    input logic       parity_odd_i,
    input logic       rx_frame_done_i,
    input logic       rx_buf_load_i,
    input logic       rx_buf_read_i,
    input logic       tx_shift_start_i,
    input logic       tx_shift_end_i,
    input logic       rx_par_sum_i,
    input logic       rx_stop_i,
    input logic       stat_wr_i,
    input logic [7:0] status_o
);

    a_r1_rxbf_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_load_i |=> status_o[1]);

    a_r2_rxbf_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_buf_read_i && !rx_buf_load_i) |=> !status_o[1]);

    a_r3_txc_end: assert property (@(posedge clk) disable iff (!rst_n)
        tx_shift_end_i |=> status_o[2]);

    a_r3_txc_start: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_shift_start_i && !tx_shift_end_i) |=> !status_o[2]);

    a_r4_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_done_i && status_o[1]) |=> status_o[3]);

    a_r5_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_done_i && mode_uart_i && parity_en_i && (rx_par_sum_i != parity_odd_i))
        |=> status_o[4]);

    a_r6_no_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_uart_i || !parity_en_i) |=> !$rose(status_o[4]));

    a_r7_framing: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_done_i && mode_uart_i && !rx_stop_i) |=> status_o[5]);

    a_r8_wr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && !rx_frame_done_i) |=> (status_o[5:3] == 3'b000));

    a_r8_wr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && !rx_buf_load_i && !rx_buf_read_i) |=> $stable(status_o[1]));

endmodule

bind serial_status_unit sp_status_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .mode_uart_i      (mode_uart_i),
    .parity_en_i      (parity_en_i),
    .parity_odd_i     (parity_odd_i),
    .rx_frame_done_i  (rx_frame_done_i),
    .rx_buf_load_i    (rx_buf_load_i),
    .rx_buf_read_i    (rx_buf_read_i),
    .tx_shift_start_i (tx_shift_start_i),
    .tx_shift_end_i   (tx_shift_end_i),
    .rx_par_sum_i     (rx_par_sum_i),
    .rx_stop_i        (rx_stop_i),
    .stat_wr_i        (stat_wr_i),
    .status_o         (status_o)
);

// File: tb/sim_serial_status_unit.sv
module sim_serial_status_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] exp;
        logic uart, pen, podd, pe, re, fd, ld, rd, ts, te, ps, st, wr;
    } vec_t;

    localparam int NV = 26;
    // Columns: exp, uart, pen, podd, pe, re, fd, ld, rd, ts, te, ps, st, wr
    localparam vec_t VECS [NV] = '{
        '{8'h06, 1,1,0,1,1, 0,1,0,0,0, 0,1,0},  // R1 load
        '{8'h06, 1,1,0,1,1, 0,0,0,0,0, 0,1,0},  // idle
        '{8'h04, 1,1,0,1,1, 0,0,1,0,0, 0,1,0},  // R2 read
        '{8'h00, 1,1,0,1,1, 0,0,0,1,0, 0,1,0},  // R3 start
        '{8'h04, 1,1,0,1,1, 0,0,0,0,1, 0,1,0},  // R3 end
        '{8'h04, 1,1,0,1,1, 0,0,0,1,1, 0,1,0},  // R3 start+end
        '{8'h06, 1,1,0,1,1, 0,1,0,0,0, 0,1,0},  // R1 load
        '{8'h0E, 1,1,0,1,1, 1,0,0,0,0, 0,1,0},  // R4 overrun uart
        '{8'h06, 1,1,0,1,1, 0,0,0,0,0, 0,1,1},  // R8 write
        '{8'h1E, 1,1,0,1,1, 1,0,0,0,0, 1,1,0},  // R5 even parity bad
        '{8'h06, 1,1,0,1,1, 0,0,0,0,0, 0,1,1},  // R8 write
        '{8'h2E, 1,1,0,1,1, 1,0,0,0,0, 0,0,0},  // R7 framing
        '{8'h2E, 1,1,0,1,1, 1,0,0,0,0, 0,0,1},  // R10 set beats write
        '{8'h2C, 1,1,0,1,1, 0,0,1,0,0, 0,1,0},  // R2 read keeps errors
        '{8'h04, 1,1,0,1,0, 0,0,0,0,0, 0,1,0},  // R9 rx enable drop
        '{8'h04, 1,1,0,1,1, 0,0,0,0,0, 0,1,0},  // idle
        '{8'h04, 0,1,0,1,1, 1,0,0,0,0, 1,0,0},  // R6 R7 sync no set
        '{8'h06, 0,1,0,1,1, 0,1,0,0,0, 0,1,0},  // R1 sync load
        '{8'h0E, 0,1,0,1,1, 1,0,0,0,0, 0,1,0},  // R4 overrun sync
        '{8'h06, 0,1,0,0,1, 0,0,0,0,0, 0,1,0},  // R9 port enable drop
        '{8'h06, 0,1,0,1,1, 0,0,0,0,0, 0,1,0},  // idle
        '{8'h0E, 1,0,0,1,1, 1,0,0,0,0, 1,1,0},  // R6 parity disabled
        '{8'h06, 1,0,0,1,1, 0,0,0,0,0, 0,1,1},  // R8 write
        '{8'h0E, 1,1,1,1,1, 1,0,0,0,0, 1,1,0},  // R5 odd parity good
        '{8'h1E, 1,1,1,1,1, 1,0,0,0,0, 0,1,1},  // R5 R10 odd bad + write
        '{8'h04, 1,1,1,1,1, 0,0,1,0,0, 0,1,1}   // R8 write + read
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_uart_i = 1'b1, parity_en_i = 1'b1, parity_odd_i = 1'b0;
    logic       port_en_i = 1'b1, rx_en_i = 1'b1;
    logic       rx_frame_done_i = 1'b0, rx_buf_load_i = 1'b0, rx_buf_read_i = 1'b0;
    logic       tx_shift_start_i = 1'b0, tx_shift_end_i = 1'b0;
    logic       rx_par_sum_i = 1'b0, rx_stop_i = 1'b1, stat_wr_i = 1'b0;
    logic [7:0] status_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .mode_uart_i(mode_uart_i),
        .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i),
        .port_en_i(port_en_i), .rx_en_i(rx_en_i),
        .rx_frame_done_i(rx_frame_done_i), .rx_buf_load_i(rx_buf_load_i),
        .rx_buf_read_i(rx_buf_read_i), .tx_shift_start_i(tx_shift_start_i),
        .tx_shift_end_i(tx_shift_end_i), .rx_par_sum_i(rx_par_sum_i),
        .rx_stop_i(rx_stop_i), .stat_wr_i(stat_wr_i), .status_o(status_o)
    );

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (status_o !== exp) begin
            n_bad++;
            $display("FAIL %s: status actual %02h expected %02h", req, status_o, exp);
        end
        if (status_o[0] !== 1'b0 || status_o[7:6] !== 2'b00) begin
            n_bad++;
            $display("FAIL R11: reserved bits actual %02h expected 0", status_o);
        end
    endtask

    task automatic apply(input vec_t v);
        mode_uart_i = v.uart; parity_en_i = v.pen; parity_odd_i = v.podd;
        port_en_i = v.pe; rx_en_i = v.re; rx_frame_done_i = v.fd;
        rx_buf_load_i = v.ld; rx_buf_read_i = v.rd; tx_shift_start_i = v.ts;
        tx_shift_end_i = v.te; rx_par_sum_i = v.ps; rx_stop_i = v.st;
        stat_wr_i = v.wr;
    endtask

    localparam vec_t IDLE = '{8'h00, 1,1,0,1,1, 0,0,0,0,0, 0,1,0};

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", 8'h04);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after release", 8'h04);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            check($sformatf("vector %0d", i), VECS[i].exp);
        end

        // R2: load and read together leaves buffer full set.
        apply('{8'h00, 1,1,0,1,1, 0,1,1,0,0, 0,1,0});
        @(negedge clk);
        check("R2 load+read", 8'h06);

        // R9: both enables drop at once after an overrun.
        apply('{8'h00, 1,1,0,1,1, 1,0,0,0,0, 0,1,0});
        @(negedge clk);
        check("R4 overrun again", 8'h0E);
        apply('{8'h00, 1,1,0,0,0, 0,0,0,0,0, 0,1,0});
        @(negedge clk);
        check("R9 both enables", 8'h06);

        // R11: mid-run reset restores 0x04.
        apply(IDLE);
        apply('{8'h00, 1,1,0,1,1, 1,0,0,1,0, 0,0,0});
        @(negedge clk);
        check("R7 framing before reset", 8'h2A);
        apply(IDLE);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid-run reset", 8'h04);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after second release", 8'h04);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule